// File: doc/BRIEF.md
# Scan Line Row and Gray Level Mapper

This block sits between the frame timing generator and the segment drivers of a matrix display controller. For every scan line index presented during a frame it works out three things: which row of display memory feeds that line, whether the line is inside the programmed multiplex window, and which physical common pin the line drives. Alongside the line index it takes the 6-bit gray level read from memory. It then returns that level after applying the current display mode. A line outside the window is always dark.

The configuration covers the start line, the display offset, the multiplex ratio, the scan-direction reversal, the odd/even pin interleave and the display mode. These settings arrive on plain inputs. They are copied into shadow registers only when a frame boundary pulse is seen, so a frame already in progress never mixes two settings. All results are registered and appear one clock after the line is presented.

Top module: `scan_gray_mapper`

## Requirements
- R1: For a presented scan line k, the output row equals (k + start line) mod 64.
- R2: The line-active flag is 1 exactly when k is below the effective multiplex ratio M.
- R3: The effective ratio M is the multiplex input clamped to the range 16..64. Values below 16 act as 16 and values above 64 act as 64. After reset M is 64.
- R4: When the line-active flag is 0, the gray output is 0 in every display mode.
- R5: Display mode encoding for active lines: 2'b00 passes the memory level unchanged, 2'b01 forces 63, 2'b10 forces 0, and 2'b11 outputs 63 minus the memory level.
- R6: The logical common index is c = (k − offset) mod 64, so the line equal to the offset lands on common 0.
- R7: When scan reversal is set, the logical index is replaced by 63 − c before interleaving.
- R8: When interleave is set, an index c' below 32 drives pin 2·c' and an index c' of 32 or more drives pin 2·(c' − 32) + 1. When interleave is clear, the pin equals c'.
- R9: out_valid is scan_valid delayed by one clock, and the data outputs are updated only for presented lines.
- R10: Configuration inputs are captured only in a cycle with frame_sync high and govern lines presented from the following cycle on. Changes without frame_sync have no effect.
- R11: After reset the outputs are zero and out_valid is 0. The shadow settings are start 0, offset 0, ratio 64, no reversal, no interleave, and normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | Frame boundary pulse that captures the configuration |
| cfg_start | input | 6 | Start line, 0..63 |
| cfg_offset | input | 6 | Display offset, 0..63 |
| cfg_mux | input | 7 | Multiplex ratio request |
| cfg_com_rev | input | 1 | Reverse scan direction |
| cfg_com_split | input | 1 | Odd/even pin interleave |
| cfg_mode | input | 2 | Display mode |
| scan_valid | input | 1 | A scan line is presented this cycle |
| scan_line | input | 6 | Scan line index k |
| ram_level | input | 6 | Gray level read from memory for this line |
| out_valid | output | 1 | Registered results are valid |
| row_addr | output | 6 | Memory row for the line |
| line_on | output | 1 | Line is within the multiplex window |
| com_pin | output | 6 | Physical common pin index |
| gray_out | output | 6 | Gray level after mode handling |

## Verification
On every cycle the assertions check the following. Consecutive lines under a steady start line step the row by one, wrapping at 64. A line outside the window is always dark. The validity flag tracks the presented line with one cycle of delay. The shadow configuration moves only after a frame pulse, and the captured ratio always lies in 16..64. The exact pin produced by each combination of offset, reversal and interleave, and the level produced by each display mode, are shown only by the bench. The bench compares every output against its own model under random settings, under clamped ratio requests, and under configuration changes made without a frame pulse.

// File: rtl/scan_pkg.sv
// Shared definitions for the scan line mapper.
// Assumes a 2-bit mode field whose encoding other blocks also decode.
package scan_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_ALL_ON  = 2'b01,
        MODE_ALL_OFF = 2'b10,
        MODE_INVERSE = 2'b11
    } gray_mode_e;
endpackage

// File: rtl/scan_cfg_shadow.sv
// Shadow register set for the mapper configuration.
// Captures all settings on a frame pulse and clamps the multiplex request
// into MUX_MIN..2**LINE_W. Assumes frame_sync lasts a single cycle per frame.
module scan_cfg_shadow
    import scan_pkg::*;
#(
    parameter int LINE_W  = 6,
    parameter int MUX_MIN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic [LINE_W-1:0] cfg_start,
    input  logic [LINE_W-1:0] cfg_offset,
    input  logic [LINE_W:0]   cfg_mux,
    input  logic              cfg_com_rev,
    input  logic              cfg_com_split,
    input  logic [1:0]        cfg_mode,
    output logic [LINE_W-1:0] s_start,
    output logic [LINE_W-1:0] s_offset,
    output logic [LINE_W:0]   s_mux,
    output logic              s_rev,
    output logic              s_split,
    output gray_mode_e        s_mode
);
    localparam int          LINES   = 2 ** LINE_W;
    localparam logic [LINE_W:0] MUX_LO = (LINE_W+1)'(MUX_MIN);
    localparam logic [LINE_W:0] MUX_HI = (LINE_W+1)'(LINES);

    logic [LINE_W:0] mux_clamped;

    // Clamp the requested ratio into the legal window.
    always_comb begin
        if (cfg_mux < MUX_LO)
            mux_clamped = MUX_LO;
        else if (cfg_mux > MUX_HI)
            mux_clamped = MUX_HI;
        else
            mux_clamped = cfg_mux;
    end

    // Capture the configuration on the frame pulse, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_start  <= '0;
            s_offset <= '0;
            s_mux    <= MUX_HI;
            s_rev    <= 1'b0;
            s_split  <= 1'b0;
            s_mode   <= MODE_NORMAL;
        end else if (frame_sync) begin
            s_start  <= cfg_start;
            s_offset <= cfg_offset;
            s_mux    <= mux_clamped;
            s_rev    <= cfg_com_rev;
            s_split  <= cfg_com_split;
            s_mode   <= gray_mode_e'(cfg_mode);
        end
    end
endmodule

// File: rtl/scan_line_map.sv
// Combinational line mapping: memory row, window test and physical pin.
// Row = line + start, logical common = line - offset, then optional
// reversal (bitwise complement equals LINES-1-c) and optional interleave.
module scan_line_map #(
    parameter int LINE_W = 6
) (
    input  logic [LINE_W-1:0] line,
    input  logic [LINE_W-1:0] start,
    input  logic [LINE_W-1:0] offset,
    input  logic [LINE_W:0]   mux,
    input  logic              rev,
    input  logic              split,
    output logic [LINE_W-1:0] row,
    output logic              active,
    output logic [LINE_W-1:0] pin
);
    logic [LINE_W-1:0] com_logical;
    logic [LINE_W-1:0] com_dir;
    logic [LINE_W-1:0] com_split;

    // Row rotation and logical common index, both modulo the line count.
    always_comb begin
        row         = line + start;
        com_logical = line - offset;
        active      = ({1'b0, line} < mux);
    end

    // Per-bit direction reversal.
    genvar b;
    generate
        for (b = 0; b < LINE_W; b++) begin : g_rev
            assign com_dir[b] = com_logical[b] ^ rev;
        end
    endgenerate

    // Interleave: lower half to even pins, upper half to odd pins.
    assign com_split = {com_dir[LINE_W-2:0], com_dir[LINE_W-1]};

    // Select the final pin.
    always_comb begin
        pin = split ? com_split : com_dir;
    end
endmodule

// File: rtl/gray_level_xform.sv
// Combinational gray level transform per display mode.
// Lines outside the window are dark whatever the mode.
module gray_level_xform
    import scan_pkg::*;
#(
    parameter int LINE_W = 6
) (
    input  logic [LINE_W-1:0] level_in,
    input  logic              active,
    input  gray_mode_e        mode,
    output logic [LINE_W-1:0] level_out
);
    localparam logic [LINE_W-1:0] FULL = '1;

    // Mode selection with window gating.
    always_comb begin
        if (!active) begin
            level_out = '0;
        end else begin
            unique case (mode)
                MODE_NORMAL:  level_out = level_in;
                MODE_ALL_ON:  level_out = FULL;
                MODE_ALL_OFF: level_out = '0;
                MODE_INVERSE: level_out = FULL - level_in;
                default:      level_out = level_in;
            endcase
        end
    end
endmodule

// File: rtl/scan_gray_mapper.sv
// Top of the scan line and gray mapper.
// Takes one line per cycle when scan_valid is high and returns its results
// one cycle later. Assumes the memory level arrives in the same cycle as its
// line index.
module scan_gray_mapper
    import scan_pkg::*;
#(
    parameter int LINE_W  = 6,
    parameter int MUX_MIN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic [LINE_W-1:0] cfg_start,
    input  logic [LINE_W-1:0] cfg_offset,
    input  logic [LINE_W:0]   cfg_mux,
    input  logic              cfg_com_rev,
    input  logic              cfg_com_split,
    input  logic [1:0]        cfg_mode,
    input  logic              scan_valid,
    input  logic [LINE_W-1:0] scan_line,
    input  logic [LINE_W-1:0] ram_level,
    output logic              out_valid,
    output logic [LINE_W-1:0] row_addr,
    output logic              line_on,
    output logic [LINE_W-1:0] com_pin,
    output logic [LINE_W-1:0] gray_out
);
    logic [LINE_W-1:0] s_start;
    logic [LINE_W-1:0] s_offset;
    logic [LINE_W:0]   s_mux;
    logic              s_rev;
    logic              s_split;
    gray_mode_e        s_mode;

    logic [LINE_W-1:0] map_row;
    logic              map_active;
    logic [LINE_W-1:0] map_pin;
    logic [LINE_W-1:0] map_gray;

    scan_cfg_shadow #(.LINE_W(LINE_W), .MUX_MIN(MUX_MIN)) u_shadow (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_sync    (frame_sync),
        .cfg_start     (cfg_start),
        .cfg_offset    (cfg_offset),
        .cfg_mux       (cfg_mux),
        .cfg_com_rev   (cfg_com_rev),
        .cfg_com_split (cfg_com_split),
        .cfg_mode      (cfg_mode),
        .s_start       (s_start),
        .s_offset      (s_offset),
        .s_mux         (s_mux),
        .s_rev         (s_rev),
        .s_split       (s_split),
        .s_mode        (s_mode)
    );

    scan_line_map #(.LINE_W(LINE_W)) u_map (
        .line   (scan_line),
        .start  (s_start),
        .offset (s_offset),
        .mux    (s_mux),
        .rev    (s_rev),
        .split  (s_split),
        .row    (map_row),
        .active (map_active),
        .pin    (map_pin)
    );

    gray_level_xform #(.LINE_W(LINE_W)) u_gray (
        .level_in  (ram_level),
        .active    (map_active),
        .mode      (s_mode),
        .level_out (map_gray)
    );

    // Validity flag follows the presented line by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= scan_valid;
    end

    // Result registers, loaded only for presented lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_addr <= '0;
            line_on  <= 1'b0;
            com_pin  <= '0;
            gray_out <= '0;
        end else if (scan_valid) begin
            row_addr <= map_row;
            line_on  <= map_active;
            com_pin  <= map_pin;
            gray_out <= map_gray;
        end
    end
endmodule

// File: rtl/scan_mapper_checker.sv
// Property checker for scan_gray_mapper, attached by bind below.
module scan_mapper_checker #(
    parameter int LINE_W  = 6,
    parameter int MUX_MIN = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_sync,
    input logic              scan_valid,
    input logic [LINE_W-1:0] scan_line,
    input logic              out_valid,
    input logic [LINE_W-1:0] row_addr,
    input logic              line_on,
    input logic [LINE_W-1:0] gray_out,
    input logic [LINE_W-1:0] s_start,
    input logic [LINE_W-1:0] s_offset,
    input logic [LINE_W:0]   s_mux,
    input logic              s_rev,
    input logic              s_split,
    input logic [1:0]        s_mode
);
    localparam int LINES = 2 ** LINE_W;

    // R1: consecutive lines under a steady start line step the row by one.
    p_row_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)
         && $past(scan_line) == LINE_W'($past(scan_line, 2) + 1'b1)
         && $past(s_start) == $past(s_start, 2))
        |-> row_addr == LINE_W'($past(row_addr) + 1'b1));

    // R4: lines outside the window are dark.
    p_dark_inactive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !line_on) |-> gray_out == '0);

    // R9: validity follows the presented line.
    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_valid |=> out_valid);

    p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_valid |=> !out_valid);

    // R10: shadow settings move only after a frame pulse.
    p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> ($stable(s_start) && $stable(s_offset) && $stable(s_mux)
                         && $stable(s_rev) && $stable(s_split) && $stable(s_mode)));

    // R3: captured ratio always lies inside the legal range.
    p_mux_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_mux >= (LINE_W+1)'(MUX_MIN)) && (s_mux <= (LINE_W+1)'(LINES)));
endmodule

bind scan_gray_mapper scan_mapper_checker #(.LINE_W(LINE_W), .MUX_MIN(MUX_MIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .scan_valid (scan_valid),
    .scan_line  (scan_line),
    .out_valid  (out_valid),
    .row_addr   (row_addr),
    .line_on    (line_on),
    .gray_out   (gray_out),
    .s_start    (s_start),
    .s_offset   (s_offset),
    .s_mux      (s_mux),
    .s_rev      (s_rev),
    .s_split    (s_split),
    .s_mode     (s_mode)
);

// File: tb/sim_scan_gray_mapper.sv
module sim_scan_gray_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic [5:0] cfg_start = '0;
    logic [5:0] cfg_offset = '0;
    logic [6:0] cfg_mux = 7'd64;
    logic       cfg_com_rev = 1'b0;
    logic       cfg_com_split = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic       scan_valid = 1'b0;
    logic [5:0] scan_line = '0;
    logic [5:0] ram_level = '0;
    logic       out_valid;
    logic [5:0] row_addr;
    logic       line_on;
    logic [5:0] com_pin;
    logic [5:0] gray_out;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // Bench copy of the settings in force.
    int m_start = 0, m_offset = 0, m_mux = 64, m_rev = 0, m_split = 0, m_mode = 0;

    scan_gray_mapper u0 (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .cfg_start(cfg_start), .cfg_offset(cfg_offset), .cfg_mux(cfg_mux),
        .cfg_com_rev(cfg_com_rev), .cfg_com_split(cfg_com_split), .cfg_mode(cfg_mode),
        .scan_valid(scan_valid), .scan_line(scan_line), .ram_level(ram_level),
        .out_valid(out_valid), .row_addr(row_addr), .line_on(line_on),
        .com_pin(com_pin), .gray_out(gray_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int clamp_mux(int v);
        if (v < 16) return 16;
        if (v > 64) return 64;
        return v;
    endfunction

    function automatic int exp_row(int k);
        return (k + m_start) % 64;
    endfunction

    function automatic int exp_on(int k);
        return (k < m_mux) ? 1 : 0;
    endfunction

    function automatic int exp_pin(int k);
        int c;
        c = (k - m_offset + 64) % 64;
        if (m_rev != 0) c = 63 - c;
        if (m_split != 0) c = (c < 32) ? 2 * c : 2 * (c - 32) + 1;
        return c;
    endfunction

    function automatic int exp_gray(int k, int lvl);
        if (exp_on(k) == 0) return 0;
        case (m_mode)
            0: return lvl;
            1: return 63;
            2: return 0;
            default: return 63 - lvl;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one line, wait for its result and compare everything.
    task automatic run_line(int k, int lvl, string tag);
        scan_valid = 1'b1;
        scan_line  = 6'(k);
        ram_level  = 6'(lvl);
        @(posedge clk); #1;
        scan_valid = 1'b0;
        check({tag, " R9 valid"}, int'(out_valid), 1);
        check({tag, " R1 row"}, int'(row_addr), exp_row(k));
        check({tag, " R2 active"}, int'(line_on), exp_on(k));
        check({tag, " R6/R7/R8 pin"}, int'(com_pin), exp_pin(k));
        check({tag, " R5/R4 gray"}, int'(gray_out), exp_gray(k, lvl));
    endtask

    // Capture a configuration, then scramble the inputs with no pulse (R10).
    task automatic load_cfg(int st, int off, int mux, int rev, int spl, int md);
        cfg_start = 6'(st); cfg_offset = 6'(off); cfg_mux = 7'(mux);
        cfg_com_rev = rev[0]; cfg_com_split = spl[0]; cfg_mode = 2'(md);
        frame_sync = 1'b1;
        @(posedge clk); #1;
        frame_sync = 1'b0;
        m_start = st; m_offset = off; m_mux = clamp_mux(mux);
        m_rev = rev; m_split = spl; m_mode = md;
        cfg_start = 6'($urandom); cfg_offset = 6'($urandom); cfg_mux = 7'($urandom);
        cfg_com_rev = 1'($urandom); cfg_com_split = 1'($urandom); cfg_mode = 2'($urandom);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'h5eed);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R11: reset state
        check("R11 out_valid", int'(out_valid), 0);
        check("R11 row", int'(row_addr), 0);
        check("R11 active", int'(line_on), 0);
        check("R11 pin", int'(com_pin), 0);
        check("R11 gray", int'(gray_out), 0);
        // R11: reset defaults, with scrambled inputs and no pulse (R10)
        cfg_start = 6'd9; cfg_offset = 6'd3; cfg_mux = 7'd20; cfg_mode = 2'b11;
        cfg_com_rev = 1'b1;
        run_line(5, 9, "R11 default");
        run_line(63, 40, "R11 default");

        // R1 example: start 4, line 57 -> 61, line 60 -> 0
        load_cfg(4, 0, 64, 0, 0, 0);
        run_line(57, 12, "R1 example");
        check("R1 row 57", int'(row_addr), 61);
        run_line(60, 12, "R1 example");
        check("R1 row 60", int'(row_addr), 0);

        // R6: offset 16 puts line 16 on pin 0
        load_cfg(0, 16, 64, 0, 0, 0);
        run_line(16, 7, "R6 offset");
        check("R6 pin zero", int'(com_pin), 0);

        // R7/R8 corners
        load_cfg(0, 0, 64, 1, 0, 0);
        run_line(0, 1, "R7 rev");
        check("R7 pin 63", int'(com_pin), 63);
        load_cfg(0, 0, 64, 0, 1, 0);
        run_line(31, 1, "R8 split");
        check("R8 pin 62", int'(com_pin), 62);
        run_line(32, 1, "R8 split");
        check("R8 pin 1", int'(com_pin), 1);

        // R3 clamps: low request acts as 16, high as 64
        load_cfg(0, 0, 3, 0, 0, 0);
        run_line(15, 20, "R3 low");
        check("R3 line15 on", int'(line_on), 1);
        run_line(16, 20, "R3 low");
        check("R3 line16 off", int'(line_on), 0);
        check("R4 line16 dark", int'(gray_out), 0);
        load_cfg(0, 0, 120, 0, 0, 1);
        run_line(63, 5, "R3 high");
        check("R3 line63 on", int'(line_on), 1);

        // R5: each mode on an active line, R4 on an inactive one
        for (int md = 0; md < 4; md++) begin
            load_cfg(7, 2, 40, 0, 0, md);
            run_line(10, 17, "R5 mode");
            run_line(45, 17, "R4 inactive");
            check("R4 inactive dark", int'(gray_out), 0);
        end

        // R9: output holds when no line is presented
        @(posedge clk); #1;
        check("R9 valid low", int'(out_valid), 0);

        // Random frames
        for (int f = 0; f < 24; f++) begin
            load_cfg(int'($urandom % 64), int'($urandom % 64), int'($urandom % 128),
                     int'($urandom % 2), int'($urandom % 2), int'($urandom % 4));
            for (int k = 0; k < 64; k++) begin
                run_line(k, int'($urandom % 64), "random");
                if (($urandom % 8) == 0) begin
                    @(posedge clk); #1;
                    check("R9 gap", int'(out_valid), 0);
                end
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule